// File: doc/BRIEF.md
# Stacked and Rotating Register Index Renamer

This block turns an architectural general-register number into a physical register index. The low registers are static and pass straight through. The registers above them form a stacked region. Each procedure call opens a new frame in that region, placed after the caller's frame on a circular file of physical stacked registers, and each return restores the caller's frame. No register contents are copied on either event.

Each frame can reserve a rotating sub-region at its bottom, sized in whole groups of registers. A rotate pulse, issued by a software-pipelined loop branch, steps a rotating base down by one, modulo the rotating size. As a result, the same architectural name lands on a fresh physical register in every loop iteration. A call starts the new frame with a rotating base of zero. A return brings back the caller's saved rotating base along with its frame.

A call is refused in three cases: its frame would not fit in the physical stacked registers, no save slot is left, or its rotating size is malformed. A refused call raises a one-cycle flag and changes nothing. The physical index is registered: it reflects the architectural index and the frame state present at the clock edge.

Top module: `regstack_renamer`

## Requirements
- R1: An architectural index below NUM_STATIC (32) appears unchanged on `phys_idx` one clock after it is presented, whatever the frame state.
- R2: For an index `a >= 32` with offset `o = a - 32` at or above the rotating size, `phys_idx = 32 + (base + o) mod 96`, where `base` is the current frame base. This holds beyond the frame's size as well, and it wraps past physical index 127 back to 32.
- R3: For an offset `o` below the rotating size `rs`, the offset is first replaced by `(o + rrb) mod rs`, where `rrb` is the rotating base, and then mapped as in R2.
- R4: A rotate pulse sets `rrb` to `rrb - 1`, or to `rs - 1` when `rrb` is 0. A rotate pulse has no effect when `rs` is 0.
- R5: An accepted call saves the current frame. It then sets the new frame base to `(base + current size) mod 96`, sets the size and rotating size from `call_size` and `call_rot`, and sets `rrb` to 0.
- R6: A return restores the most recently saved frame exactly, including its `rrb`. A return with no saved frame is ignored.
- R7: A call is refused with `stack_ovf` high for exactly the next cycle, and with the mapping unchanged, in either of two cases: the sum of all live frame sizes plus `call_size` exceeds 96, or DEPTH frames are already saved. Without a call, `stack_ovf` stays low.
- R8: A call whose `call_rot` is not a multiple of 8, or is larger than `call_size`, is refused with `rot_bad` high for the next cycle and the mapping unchanged. This check takes priority over R7, so the two flags are never high together.
- R9: When several controls arrive in one cycle, a call takes priority over a return, and a return takes priority over a rotate pulse. Only the winner acts.
- R10: Reset (synchronous, active high) empties the save stack and zeroes the frame base, frame size, rotating size and rotating base, so that every index maps to itself. Reset also clears `phys_idx` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arch_idx | input | 7 | Architectural register number |
| call_en | input | 1 | Open a new frame |
| call_size | input | 7 | Size of the new frame in registers |
| call_rot | input | 7 | Rotating size of the new frame (multiple of 8) |
| ret_en | input | 1 | Return to the caller's frame |
| rot_pulse | input | 1 | Loop-branch rotate step |
| phys_idx | output | 7 | Registered physical register index |
| stack_ovf | output | 1 | Previous call refused for lack of room |
| rot_bad | output | 1 | Previous call refused for a malformed rotating size |

## Verification
The bench builds the block with the default 32 static and 96 stacked registers, but with a save-stack DEPTH of 4. This lets a short call chain reach both refusal causes: four nested frames that fill the stack, and a frame that would overrun the 96 registers. The same chain places a frame base near the top of the circular file, so the modulo-96 wrap, the rotating wrap in both directions, and the exact restore of saved rotating bases are all within a few dozen cycles.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_ROT  = 2'd3
  } rr_op_e;

  // Adds two values each already below m and folds the sum back below m.
  function automatic int rr_wrap_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

endpackage

// File: rtl/rr_op_decode.sv
module rr_op_decode
  import rr_pkg::*;
(
  input  logic   call_en,
  input  logic   ret_en,
  input  logic   rot_pulse,
  output rr_op_e op
);

  // Fixed priority: call, then return, then rotate (R9).
  always_comb begin
    if (call_en)        op = OP_CALL;
    else if (ret_en)    op = OP_RET;
    else if (rot_pulse) op = OP_ROT;
    else                op = OP_NONE;
  end

endmodule

// File: rtl/rr_frame_stack.sv
module rr_frame_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  assign wr_addr = ADDR_W'(sp);
  assign rd_addr = ADDR_W'(sp - PTR_W'(1));
  assign full    = (sp == PTR_W'(DEPTH));
  assign empty   = (sp == '0);

  // Write port only, no reset, so the array maps to RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_addr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                  sp <= '0;
    else if (push && !full)   sp <= sp + PTR_W'(1);
    else if (pop && !empty)   sp <= sp - PTR_W'(1);
  end

  assign top_data = empty ? '0 : mem[rd_addr];

endmodule

// File: rtl/rr_frame_ctrl.sv
module rr_frame_ctrl
  import rr_pkg::*;
#(
  parameter int NUM_STACKED = 96,
  parameter int ROT_GRAN    = 8,
  parameter int DEPTH       = 16,
  parameter int SZ_W        = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            call_en,
  input  logic [SZ_W-1:0] call_size,
  input  logic [SZ_W-1:0] call_rot,
  input  logic            ret_en,
  input  logic            rot_pulse,
  output logic [SZ_W-1:0] frame_base,
  output logic [SZ_W-1:0] rot_size,
  output logic [SZ_W-1:0] rot_base,
  output logic            stack_ovf,
  output logic            rot_bad
);

  localparam int REC_W = 4 * SZ_W;

  rr_op_e            op;
  logic [SZ_W-1:0]   base_q, size_q, rot_q, rrb_q, alloc_q;
  logic [SZ_W-1:0]   next_base, rrb_dec;
  logic [SZ_W:0]     alloc_sum;
  logic [REC_W-1:0]  push_rec, top_rec;
  logic              stk_full, stk_empty;
  logic              rot_ok, room_ok;
  logic              call_go, ret_go, rot_go;

  rr_op_decode u_dec (
    .call_en   (call_en),
    .ret_en    (ret_en),
    .rot_pulse (rot_pulse),
    .op        (op)
  );

  assign push_rec = {base_q, size_q, rot_q, rrb_q};

  rr_frame_stack #(
    .DEPTH (DEPTH),
    .WIDTH (REC_W)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (call_go),
    .pop       (ret_go),
    .push_data (push_rec),
    .top_data  (top_rec),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  assign alloc_sum = {1'b0, alloc_q} + {1'b0, call_size};
  assign rot_ok    = ((int'(call_rot) % ROT_GRAN) == 0) && (call_rot <= call_size);
  assign room_ok   = (alloc_sum <= (SZ_W + 1)'(NUM_STACKED)) && !stk_full;

  assign call_go = (op == OP_CALL) && rot_ok && room_ok;
  assign ret_go  = (op == OP_RET) && !stk_empty;
  assign rot_go  = (op == OP_ROT) && (rot_q != '0);

  assign next_base = SZ_W'(rr_wrap_add(int'(base_q), int'(size_q), NUM_STACKED));
  assign rrb_dec   = (rrb_q == '0) ? (rot_q - SZ_W'(1)) : (rrb_q - SZ_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      size_q    <= '0;
      rot_q     <= '0;
      rrb_q     <= '0;
      alloc_q   <= '0;
      stack_ovf <= 1'b0;
      rot_bad   <= 1'b0;
    end else begin
      rot_bad   <= (op == OP_CALL) && !rot_ok;
      stack_ovf <= (op == OP_CALL) && rot_ok && !room_ok;
      if (call_go) begin
        base_q  <= next_base;
        size_q  <= call_size;
        rot_q   <= call_rot;
        rrb_q   <= '0;
        alloc_q <= alloc_sum[SZ_W-1:0];
      end else if (ret_go) begin
        {base_q, size_q, rot_q, rrb_q} <= top_rec;
        alloc_q <= alloc_q - size_q;
      end else if (rot_go) begin
        rrb_q <= rrb_dec;
      end
    end
  end

  assign frame_base = base_q;
  assign rot_size   = rot_q;
  assign rot_base   = rrb_q;

endmodule

// File: rtl/rr_index_map.sv
module rr_index_map
  import rr_pkg::*;
#(
  parameter int NUM_STATIC  = 32,
  parameter int NUM_STACKED = 96,
  parameter int PH_W        = 7,
  parameter int SZ_W        = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] arch_idx,
  input  logic [SZ_W-1:0] frame_base,
  input  logic [SZ_W-1:0] rot_size,
  input  logic [SZ_W-1:0] rot_base,
  output logic [PH_W-1:0] phys_idx
);

  logic [PH_W-1:0] phys_d;
  int              off_i;

  always_comb begin
    off_i  = 0;
    phys_d = arch_idx;
    if (int'(arch_idx) >= NUM_STATIC) begin
      off_i = int'(arch_idx) - NUM_STATIC;
      if (off_i < int'(rot_size))
        off_i = rr_wrap_add(off_i, int'(rot_base), int'(rot_size));
      phys_d = PH_W'(NUM_STATIC + rr_wrap_add(int'(frame_base), off_i, NUM_STACKED));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phys_idx <= '0;
    else     phys_idx <= phys_d;
  end

endmodule

// File: rtl/regstack_renamer.sv
module regstack_renamer #(
  parameter int NUM_STATIC  = 32,
  parameter int NUM_STACKED = 96,
  parameter int ROT_GRAN    = 8,
  parameter int DEPTH       = 16,
  localparam int PH_W       = $clog2(NUM_STATIC + NUM_STACKED),
  localparam int SZ_W       = $clog2(NUM_STACKED + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] arch_idx,
  input  logic            call_en,
  input  logic [SZ_W-1:0] call_size,
  input  logic [SZ_W-1:0] call_rot,
  input  logic            ret_en,
  input  logic            rot_pulse,
  output logic [PH_W-1:0] phys_idx,
  output logic            stack_ovf,
  output logic            rot_bad
);

  logic [SZ_W-1:0] frame_base, rot_size, rot_base;

  rr_frame_ctrl #(
    .NUM_STACKED (NUM_STACKED),
    .ROT_GRAN    (ROT_GRAN),
    .DEPTH       (DEPTH),
    .SZ_W        (SZ_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .call_en    (call_en),
    .call_size  (call_size),
    .call_rot   (call_rot),
    .ret_en     (ret_en),
    .rot_pulse  (rot_pulse),
    .frame_base (frame_base),
    .rot_size   (rot_size),
    .rot_base   (rot_base),
    .stack_ovf  (stack_ovf),
    .rot_bad    (rot_bad)
  );

  rr_index_map #(
    .NUM_STATIC  (NUM_STATIC),
    .NUM_STACKED (NUM_STACKED),
    .PH_W        (PH_W),
    .SZ_W        (SZ_W)
  ) u_map (
    .clk        (clk),
    .rst        (rst),
    .arch_idx   (arch_idx),
    .frame_base (frame_base),
    .rot_size   (rot_size),
    .rot_base   (rot_base),
    .phys_idx   (phys_idx)
  );

endmodule

// File: rtl/regstack_renamer_chk.sv
module regstack_renamer_chk #(
  parameter int NUM_STATIC = 32,
  parameter int PH_W       = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [PH_W-1:0] arch_idx,
  input logic            call_en,
  input logic [PH_W-1:0] phys_idx,
  input logic            stack_ovf,
  input logic            rot_bad
);

  AST_STATIC_PASS: assert property (@(posedge clk) disable iff (rst)
    (int'(arch_idx) < NUM_STATIC) |=> (phys_idx == $past(arch_idx)));   // R1

  AST_STACKED_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(arch_idx) >= NUM_STATIC) |=> (int'(phys_idx) >= NUM_STATIC));  // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !call_en |=> !stack_ovf);                                              // R7

  AST_NO_ROT_BAD: assert property (@(posedge clk) disable iff (rst)
    !call_en |=> !rot_bad);                                                // R8

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stack_ovf, rot_bad}));                                       // R8

endmodule

bind regstack_renamer regstack_renamer_chk #(
  .NUM_STATIC (NUM_STATIC),
  .PH_W       (PH_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .arch_idx  (arch_idx),
  .call_en   (call_en),
  .phys_idx  (phys_idx),
  .stack_ovf (stack_ovf),
  .rot_bad   (rot_bad)
);

// File: tb/regstack_renamer_tb_top.sv
`timescale 1ns/1ps
module regstack_renamer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] arch_idx = '0;
  logic       call_en = 1'b0;
  logic [6:0] call_size = '0;
  logic [6:0] call_rot = '0;
  logic       ret_en = 1'b0;
  logic       rot_pulse = 1'b0;
  logic [6:0] phys_idx;
  logic       stack_ovf;
  logic       rot_bad;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  regstack_renamer #(.DEPTH(4)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .arch_idx  (arch_idx),
    .call_en   (call_en),
    .call_size (call_size),
    .call_rot  (call_rot),
    .ret_en    (ret_en),
    .rot_pulse (rot_pulse),
    .phys_idx  (phys_idx),
    .stack_ovf (stack_ovf),
    .rot_bad   (rot_bad)
  );

  // op: 0 idle, 1 call, 2 return, 3 rotate
  typedef struct packed {
    logic [1:0] op;
    logic [6:0] sz;
    logic [6:0] rs;
    logic [6:0] ar;
    logic [6:0] ph;
    logic       ovf;
    logic       bad;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0,  7'd0,  7'd0,  7'd5,   7'd5,   1'b0, 1'b0, 4'd1},  // R1 static at reset
    '{2'd0,  7'd0,  7'd0,  7'd40,  7'd40,  1'b0, 1'b0, 4'd2},  // R2 identity frame
    '{2'd1,  7'd20, 7'd8,  7'd35,  7'd35,  1'b0, 1'b0, 4'd5},  // R5 first call
    '{2'd3,  7'd0,  7'd0,  7'd33,  7'd32,  1'b0, 1'b0, 4'd4},  // R4 rrb 0 -> 7
    '{2'd3,  7'd0,  7'd0,  7'd39,  7'd37,  1'b0, 1'b0, 4'd3},  // R3 rrb 6
    '{2'd0,  7'd0,  7'd0,  7'd45,  7'd45,  1'b0, 1'b0, 4'd2},  // R2 above rotating part
    '{2'd1,  7'd30, 7'd16, 7'd32,  7'd52,  1'b0, 1'b0, 4'd5},  // R5 base 20
    '{2'd3,  7'd0,  7'd0,  7'd32,  7'd67,  1'b0, 1'b0, 4'd4},  // R4 rrb 15
    '{2'd0,  7'd0,  7'd0,  7'd31,  7'd31,  1'b0, 1'b0, 4'd1},  // R1 static in frame
    '{2'd1,  7'd50, 7'd0,  7'd33,  7'd52,  1'b1, 1'b0, 4'd7},  // R7 too large
    '{2'd1,  7'd40, 7'd8,  7'd71,  7'd121, 1'b0, 1'b0, 4'd2},  // R2 base 50
    '{2'd1,  7'd6,  7'd0,  7'd38,  7'd32,  1'b0, 1'b0, 4'd2},  // R2 wrap past 127
    '{2'd1,  7'd0,  7'd0,  7'd37,  7'd127, 1'b1, 1'b0, 4'd7},  // R7 stack full
    '{2'd1,  7'd8,  7'd3,  7'd37,  7'd127, 1'b0, 1'b1, 4'd8},  // R8 not multiple of 8
    '{2'd2,  7'd0,  7'd0,  7'd33,  7'd83,  1'b0, 1'b0, 4'd6},  // R6 back to base 50
    '{2'd2,  7'd0,  7'd0,  7'd32,  7'd67,  1'b0, 1'b0, 4'd6},  // R6 rrb 15 restored
    '{2'd2,  7'd0,  7'd0,  7'd32,  7'd38,  1'b0, 1'b0, 4'd6},  // R6 rrb 6 restored
    '{2'd2,  7'd0,  7'd0,  7'd40,  7'd40,  1'b0, 1'b0, 4'd6},  // R6 outermost
    '{2'd2,  7'd0,  7'd0,  7'd40,  7'd40,  1'b0, 1'b0, 4'd6},  // R6 empty return
    '{2'd3,  7'd0,  7'd0,  7'd40,  7'd40,  1'b0, 1'b0, 4'd4},  // R4 no rotating part
    '{2'd1,  7'd16, 7'd24, 7'd40,  7'd40,  1'b0, 1'b1, 4'd8}   // R8 rot above size
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; flags are readable on return.
  task automatic pulse(input logic c, input logic r, input logic p,
                       input logic [6:0] sz, input logic [6:0] rs);
    call_en = c; ret_en = r; rot_pulse = p; call_size = sz; call_rot = rs;
    @(posedge clk); @(negedge clk);
    call_en = 1'b0; ret_en = 1'b0; rot_pulse = 1'b0;
  endtask

  task automatic lookup(input logic [6:0] a, output logic [6:0] p);
    arch_idx = a;
    @(posedge clk); @(negedge clk);
    p = phys_idx;
  endtask

  initial begin
    logic [6:0] got;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset phys", int'(phys_idx), 0);
    check("R10 reset ovf", int'(stack_ovf), 0);
    check("R10 reset bad", int'(rot_bad), 0);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i].op == 2'd1, VEC[i].op == 2'd2, VEC[i].op == 2'd3, VEC[i].sz, VEC[i].rs);
      $sformat(tag, "R7 ovf row %0d", i);
      check(tag, int'(stack_ovf), int'(VEC[i].ovf));
      $sformat(tag, "R8 bad row %0d", i);
      check(tag, int'(rot_bad), int'(VEC[i].bad));
      lookup(VEC[i].ar, got);
      $sformat(tag, "R%0d map row %0d", VEC[i].req, i);
      check(tag, int'(got), int'(VEC[i].ph));
    end

    // R9: call beats return and rotate
    pulse(1'b1, 1'b1, 1'b1, 7'd16, 7'd16);
    lookup(7'd32, got);
    check("R9 call wins", int'(got), 32);
    pulse(1'b0, 1'b0, 1'b1, 7'd0, 7'd0);
    lookup(7'd32, got);
    check("R4 wrap to top", int'(got), 47);
    // R9: return beats rotate
    pulse(1'b0, 1'b1, 1'b1, 7'd0, 7'd0);
    lookup(7'd33, got);
    check("R9 return wins", int'(got), 33);

    // R10: reset mid-run
    pulse(1'b1, 1'b0, 1'b0, 7'd24, 7'd8);
    pulse(1'b0, 1'b0, 1'b1, 7'd0, 7'd0);
    lookup(7'd32, got);
    check("R4 before reset", int'(got), 39);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10 flags after reset", int'(stack_ovf | rot_bad), 0);
    lookup(7'd32, got);
    check("R10 identity after reset", int'(got), 32);
    pulse(1'b0, 1'b1, 1'b0, 7'd0, 7'd0);
    lookup(7'd40, got);
    check("R6 return after reset", int'(got), 40);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule